// File: doc/BRIEF.md
# Interrupt Entry and Abort Sequencer

This block sits beside a simple execute stage and decides in which cycle a pending interrupt is taken. Requests come from a non-maskable line and seven maskable priority levels. When a request is accepted while a multiply, divide or other multi-cycle operation is still running, the block cancels that operation in the same cycle. It records that the operation must run again. The saved program counter is the address of the cancelled instruction, so the return path starts it again from the beginning.

Entry stores only the 32-bit program counter and the 16-bit status word, 6 bytes in all, in two stack writes. The block then loads a handler address chosen by the accepted class and sets the status-word mask to the accepted level. A return request reads the two values back, restores them and clears the restart flag. Reset is asynchronous and bypasses the save and abort logic. In the first cycle after reset is released, the block loads a fixed boot address.

Top module: `intr_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the block loads the boot address `RST_VEC` into the program counter and status word 0. In that cycle it issues no stack write, raises no abort and accepts no request, even when requests are present or an operation is busy. After reset the stack pointer equals `SP_INIT`.
- R2: When a request is accepted, the non-maskable request wins over any maskable request. Among maskable requests the lowest level number wins.
- R3: A maskable request at level L (bit L of `lvl_req`) is accepted only when L is numerically below the mask held in status-word bits [10:8]. A request that fails this test causes no stack write and no stall. The non-maskable request ignores the mask.
- R4: `mc_abort` is high in the acceptance cycle exactly when `mc_busy` is high in that cycle. It is low in every other cycle.
- R5: After an entry, `restart_flag` is 1 if that entry aborted an operation and 0 if it did not. It drops to 0 when a return completes.
- R6: Each entry makes exactly two stack writes, in the two cycles after acceptance. The first writes the program counter of the acceptance cycle to address SP-4 with byte enables 4'b1111. The second writes the status word, zero-extended, to address SP-8 with byte enables 4'b0011.
- R7: In the cycle of the second write, the block loads the handler address and the new status word. The handler address is `VEC_BASE` for the non-maskable request and `VEC_BASE + (L+1)*VEC_STRIDE` for level L. The new status word is the old one with bits [10:8] replaced by L, or by 0 for the non-maskable request. The stack pointer then falls by 8: 6 data bytes and 2 bytes of padding.
- R8: A return request in an idle cycle with no interrupt accepted reads address SP+4 and then address SP in the next two cycles. Read data arrives one cycle after each read. In the following cycle the block loads the first word as the program counter and the low 16 bits of the second word as the status word, and the stack pointer rises by 8.
- R9: While an entry or return sequence is running, `stall` is high and no new request is accepted. A request pulse given during a sequence leaves no trace once the sequence ends.
- R10: When a return request and an accepted interrupt occur in the same cycle, the interrupt is taken, no stack read is issued, and the saved program counter is the address of the return instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req | input | 1 | Non-maskable request |
| lvl_req | input | 7 | Maskable requests, bit L is level L |
| cur_pc | input | 32 | Address of the instruction in execute |
| cur_psw | input | 16 | Current status word, mask in bits [10:8] |
| mc_busy | input | 1 | Multi-cycle operation in flight |
| rti_req | input | 1 | Return instruction in execute |
| mem_rd_data | input | 32 | Stack read data, one cycle after the read |
| mc_abort | output | 1 | Cancel the multi-cycle operation, discard its result |
| stall | output | 1 | Hold the execute stage |
| restart_flag | output | 1 | Last entry cancelled an operation |
| pc_load | output | 1 | Load the program counter |
| pc_load_val | output | 32 | Value to load into the program counter |
| psw_load | output | 1 | Load the status word |
| psw_load_val | output | 16 | Value to load into the status word |
| sp_val | output | 32 | Stack pointer |
| mem_wr_en | output | 1 | Stack write strobe |
| mem_wr_addr | output | 32 | Stack write address |
| mem_wr_data | output | 32 | Stack write data |
| mem_wr_be | output | 4 | Stack write byte enables |
| mem_rd_en | output | 1 | Stack read strobe |
| mem_rd_addr | output | 32 | Stack read address |

## Verification
The table-driven part tries the acceptance logic with single requests, several levels at once, all levels together with the non-maskable line, and requests at, just above and just below the mask. These cases separate a wrong priority order from a wrong mask comparison or an off-by-one mask. Each case is run once with a busy operation and once without, so that an abort raised on idle cycles, or a missing abort, shows up in the same cycle. Directed cases cover boot with requests present, a request pulse during a save sequence, a return and interrupt in the same cycle, and a full return. The return case checks the restored values, the stack pointer and the cleared restart flag.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int PC_W   = 32;
  localparam int PSW_W  = 16;
  localparam int NLVL   = 7;
  localparam int LVL_W  = 3;
  localparam int IM_LSB = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SV_PC, ST_SV_PSW, ST_RT_PC, ST_RT_PSW, ST_RT_END
  } seq_st_t;

  function automatic logic [LVL_W-1:0] psw_mask(input logic [PSW_W-1:0] p);
    return p[IM_LSB +: LVL_W];
  endfunction

  function automatic logic [PSW_W-1:0] psw_with_mask(input logic [PSW_W-1:0] p,
                                                     input logic [LVL_W-1:0] m);
    logic [PSW_W-1:0] r;
    r = p;
    r[IM_LSB +: LVL_W] = m;
    return r;
  endfunction

  function automatic logic [PC_W-1:0] vec_addr(input logic [PC_W-1:0] base,
                                               input logic [PC_W-1:0] stride,
                                               input logic is_nmi,
                                               input logic [LVL_W-1:0] lvl);
    if (is_nmi) return base;
    return base + (PC_W'(lvl) + PC_W'(1)) * stride;
  endfunction
endpackage

// File: rtl/intr_pick.sv
module intr_pick
  import intr_seq_pkg::*;
#(
  parameter int N  = NLVL,
  parameter int LW = LVL_W
) (
  input  logic          enable,
  input  logic          nmi_req,
  input  logic [N-1:0]  lvl_req,
  input  logic [LW-1:0] mask,
  output logic          take,
  output logic          sel_nmi,
  output logic [LW-1:0] sel_lvl
);
  logic [N-1:0] elig;
  logic         found;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = lvl_req[g] && (LW'(g) < mask);
  end

  always_comb begin
    found   = 1'b0;
    sel_lvl = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found   = 1'b1;
        sel_lvl = LW'(i);
      end
    end
  end

  assign sel_nmi = nmi_req;
  assign take    = enable && (nmi_req || found);
endmodule

// File: rtl/intr_vec.sv
module intr_vec
  import intr_seq_pkg::*;
#(
  parameter logic [PC_W-1:0] VEC_BASE   = 32'h0000_0100,
  parameter logic [PC_W-1:0] VEC_STRIDE = 32'h0000_0008
) (
  input  logic              is_nmi,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [PSW_W-1:0]  psw_in,
  output logic [PC_W-1:0]   vec,
  output logic [PSW_W-1:0]  psw_new
);
  assign vec     = vec_addr(VEC_BASE, VEC_STRIDE, is_nmi, lvl);
  assign psw_new = psw_with_mask(psw_in, is_nmi ? '0 : lvl);
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter logic [PC_W-1:0]  VEC_BASE   = 32'h0000_0100,
  parameter logic [PC_W-1:0]  VEC_STRIDE = 32'h0000_0008,
  parameter logic [PC_W-1:0]  RST_VEC    = 32'h4000_0000,
  parameter logic [PC_W-1:0]  SP_INIT    = 32'h0000_8000,
  parameter logic [PSW_W-1:0] PSW_RST    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic [NLVL-1:0]   lvl_req,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PSW_W-1:0]  cur_psw,
  input  logic              mc_busy,
  input  logic              rti_req,
  input  logic [PC_W-1:0]   mem_rd_data,
  output logic              mc_abort,
  output logic              stall,
  output logic              restart_flag,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_load_val,
  output logic              psw_load,
  output logic [PSW_W-1:0]  psw_load_val,
  output logic [PC_W-1:0]   sp_val,
  output logic              mem_wr_en,
  output logic [PC_W-1:0]   mem_wr_addr,
  output logic [PC_W-1:0]   mem_wr_data,
  output logic [3:0]        mem_wr_be,
  output logic              mem_rd_en,
  output logic [PC_W-1:0]   mem_rd_addr
);
  localparam logic [PC_W-1:0] FRAME  = PC_W'(8);
  localparam logic [PC_W-1:0] PC_OFS = PC_W'(4);
  localparam int              PAD_W  = PC_W - PSW_W;

  seq_st_t           st;
  logic              boot;
  logic [PC_W-1:0]   sp, pc_q, ret_pc_q;
  logic [PSW_W-1:0]  psw_q;
  logic              nmi_q, abort_q;
  logic [LVL_W-1:0]  lvl_q;

  // named events for the checker
  logic              idle, take_evt, ret_evt, boot_evt, ret_done, save_pc, save_psw;
  logic              sel_nmi;
  logic [LVL_W-1:0]  sel_lvl;
  logic [PC_W-1:0]   vec;
  logic [PSW_W-1:0]  psw_new;

  assign boot_evt = boot;
  assign idle     = (st == ST_IDLE) && !boot;
  assign save_pc  = (st == ST_SV_PC);
  assign save_psw = (st == ST_SV_PSW);
  assign ret_done = (st == ST_RT_END);

  intr_pick #(.N(NLVL), .LW(LVL_W)) u_pick (
    .enable  (idle),
    .nmi_req (nmi_req),
    .lvl_req (lvl_req),
    .mask    (psw_mask(cur_psw)),
    .take    (take_evt),
    .sel_nmi (sel_nmi),
    .sel_lvl (sel_lvl)
  );

  intr_vec #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_vec (
    .is_nmi  (nmi_q),
    .lvl     (lvl_q),
    .psw_in  (psw_q),
    .vec     (vec),
    .psw_new (psw_new)
  );

  assign ret_evt      = idle && rti_req && !take_evt;
  assign mc_abort     = take_evt && mc_busy;
  assign stall        = boot || (st != ST_IDLE) || take_evt || ret_evt;
  assign restart_flag = abort_q;
  assign sp_val       = sp;

  assign mem_wr_en   = save_pc || save_psw;
  assign mem_wr_addr = save_pc ? (sp - PC_OFS) : (sp - FRAME);
  assign mem_wr_data = save_pc ? pc_q : {{PAD_W{1'b0}}, psw_q};
  assign mem_wr_be   = save_pc ? 4'b1111 : 4'b0011;

  assign mem_rd_en   = (st == ST_RT_PC) || (st == ST_RT_PSW);
  assign mem_rd_addr = (st == ST_RT_PC) ? (sp + PC_OFS) : sp;

  assign pc_load      = boot || save_psw || ret_done;
  assign pc_load_val  = boot ? RST_VEC : (save_psw ? vec : ret_pc_q);
  assign psw_load     = pc_load;
  assign psw_load_val = boot ? PSW_RST : (save_psw ? psw_new : mem_rd_data[PSW_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      boot     <= 1'b1;
      sp       <= SP_INIT;
      pc_q     <= '0;
      psw_q    <= '0;
      nmi_q    <= 1'b0;
      lvl_q    <= '0;
      abort_q  <= 1'b0;
      ret_pc_q <= '0;
    end else begin
      boot <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take_evt) begin
            pc_q    <= cur_pc;
            psw_q   <= cur_psw;
            nmi_q   <= sel_nmi;
            lvl_q   <= sel_lvl;
            abort_q <= mc_busy;
            st      <= ST_SV_PC;
          end else if (ret_evt) begin
            st <= ST_RT_PC;
          end
        end
        ST_SV_PC:  st <= ST_SV_PSW;
        ST_SV_PSW: begin
          sp <= sp - FRAME;
          st <= ST_IDLE;
        end
        ST_RT_PC:  st <= ST_RT_PSW;
        ST_RT_PSW: begin
          ret_pc_q <= mem_rd_data;
          st       <= ST_RT_END;
        end
        ST_RT_END: begin
          sp      <= sp + FRAME;
          abort_q <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk
  import intr_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              boot_evt,
  input logic              take_evt,
  input logic              sel_nmi,
  input logic [LVL_W-1:0]  sel_lvl,
  input logic              nmi_req,
  input logic [PSW_W-1:0]  cur_psw,
  input logic              mc_abort,
  input logic              stall,
  input logic              mem_wr_en,
  input logic [3:0]        mem_wr_be,
  input logic              pc_load,
  input logic [PC_W-1:0]   sp_val,
  input logic              ret_done,
  input logic              restart_flag,
  input logic              mem_rd_en,
  input logic [PC_W-1:0]   mem_rd_addr
);
  AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    boot_evt |-> (!mem_wr_en && !mc_abort && pc_load)); // R1
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && nmi_req) |-> sel_nmi); // R2
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && !sel_nmi) |-> (sel_lvl < psw_mask(cur_psw))); // R3
  AST_ABORT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    mc_abort |=> (mem_wr_en && mem_wr_be == 4'b1111)); // R4
  AST_RESTART_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> !restart_flag); // R5
  AST_SAVE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wr_be == 4'b1111) |=> (mem_wr_en && mem_wr_be == 4'b0011)); // R6
  AST_VEC_WITH_PSW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wr_be == 4'b0011) |-> pc_load); // R7
  AST_SP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wr_be == 4'b0011) |=> (sp_val == $past(sp_val) - 32'd8)); // R7
  AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_rd_addr != sp_val) |=> (mem_rd_en && mem_rd_addr == sp_val)); // R8
  AST_SEQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || mem_rd_en) |-> (stall && !take_evt)); // R9
endmodule

bind intr_seq intr_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .boot_evt     (boot_evt),
  .take_evt     (take_evt),
  .sel_nmi      (sel_nmi),
  .sel_lvl      (sel_lvl),
  .nmi_req      (nmi_req),
  .cur_psw      (cur_psw),
  .mc_abort     (mc_abort),
  .stall        (stall),
  .mem_wr_en    (mem_wr_en),
  .mem_wr_be    (mem_wr_be),
  .pc_load      (pc_load),
  .sp_val       (sp_val),
  .ret_done     (ret_done),
  .restart_flag (restart_flag),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_addr  (mem_rd_addr)
);

// File: tb/test_intr_seq.sv
`timescale 1ns/1ps
module test_intr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0;
  logic [6:0]  lvl_req = '0;
  logic [31:0] cur_pc = '0;
  logic [15:0] cur_psw = '0;
  logic        mc_busy = 1'b0;
  logic        rti_req = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mc_abort, stall, restart_flag, pc_load, psw_load;
  logic [31:0] pc_load_val, sp_val, mem_wr_addr, mem_wr_data, mem_rd_addr;
  logic [15:0] psw_load_val;
  logic        mem_wr_en, mem_rd_en;
  logic [3:0]  mem_wr_be;

  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam logic [31:0] BOOT = 32'h4000_0000;
  localparam logic [31:0] SP0  = 32'h0000_8000;

  always #10 clk = ~clk;

  intr_seq i_intr_seq (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .lvl_req(lvl_req),
    .cur_pc(cur_pc), .cur_psw(cur_psw), .mc_busy(mc_busy), .rti_req(rti_req),
    .mem_rd_data(mem_rd_data), .mc_abort(mc_abort), .stall(stall),
    .restart_flag(restart_flag), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .psw_load(psw_load), .psw_load_val(psw_load_val), .sp_val(sp_val),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_be(mem_wr_be), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr)
  );

  // stack memory model
  logic [31:0] smem [256];
  always @(posedge clk) begin
    if (mem_wr_en)
      for (int b = 0; b < 4; b++)
        if (mem_wr_be[b]) smem[mem_wr_addr[9:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
    if (mem_rd_en) mem_rd_data <= smem[mem_rd_addr[9:2]];
  end

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_sp;
  logic [31:0] last_pc;
  logic [15:0] last_psw;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       nmi;
    logic [6:0] req;
    logic [2:0] mask;
    logic       busy;
    logic       take;
    logic       enmi;
    logic [2:0] elvl;
    logic       eab;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 7'b0000001, 3'd7, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0},
    '{1'b0, 7'b1000000, 3'd7, 1'b1, 1'b1, 1'b0, 3'd6, 1'b1},
    '{1'b0, 7'b1000000, 3'd6, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},
    '{1'b0, 7'b0100000, 3'd6, 1'b1, 1'b1, 1'b0, 3'd5, 1'b1},
    '{1'b0, 7'b0001010, 3'd7, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0},
    '{1'b1, 7'b1111111, 3'd0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1},
    '{1'b0, 7'b1111111, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},
    '{1'b0, 7'b0011000, 3'd4, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0},
    '{1'b0, 7'b0010000, 3'd4, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0},
    '{1'b1, 7'b0000000, 3'd0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0},
    '{1'b0, 7'b0000000, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0},
    '{1'b0, 7'b0000100, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},
    '{1'b0, 7'b0000100, 3'd3, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1}
  };

  function automatic logic [31:0] want_vec(input logic is_nmi, input logic [2:0] l);
    logic [31:0] v;
    v = BASE;
    if (!is_nmi) for (int k = 0; k <= int'(l); k++) v = v + 32'd8;
    return v;
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    logic [31:0] pc;
    logic [15:0] psw, npsw;
    pc  = 32'h1000 + 32'(idx) * 4;
    psw = 16'h005A | (16'(v.mask) << 8);
    npsw = psw;
    npsw[10:8] = v.enmi ? 3'd0 : v.elvl;
    @(negedge clk);
    nmi_req = v.nmi; lvl_req = v.req; mc_busy = v.busy; cur_pc = pc; cur_psw = psw;
    #2;
    chk(mc_abort == v.eab, "R4 abort in accept cycle", 32'(mc_abort), 32'(v.eab));
    chk(stall == v.take, "R2/R3 acceptance", 32'(stall), 32'(v.take));
    @(negedge clk);
    nmi_req = 0; lvl_req = '0; mc_busy = 0;
    #2;
    chk(mem_wr_en == v.take, "R3 write only when accepted", 32'(mem_wr_en), 32'(v.take));
    if (v.take) begin
      chk(mem_wr_addr == exp_sp - 4 && mem_wr_data == pc && mem_wr_be == 4'hF,
          "R6 pc save", mem_wr_data, pc);
      @(negedge clk); #2;
      chk(mem_wr_en && mem_wr_addr == exp_sp - 8 && mem_wr_data == {16'h0, psw}
          && mem_wr_be == 4'h3, "R6 psw save", mem_wr_data, {16'h0, psw});
      chk(pc_load && pc_load_val == want_vec(v.enmi, v.elvl), "R7 vector R2 priority",
          pc_load_val, want_vec(v.enmi, v.elvl));
      chk(psw_load && psw_load_val == npsw, "R7 new mask", 32'(psw_load_val), 32'(npsw));
      @(negedge clk); #2;
      exp_sp = exp_sp - 8;
      chk(sp_val == exp_sp, "R7 sp drop", sp_val, exp_sp);
      chk(restart_flag == v.eab, "R5 restart flag", 32'(restart_flag), 32'(v.eab));
      last_pc = pc; last_psw = psw;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    exp_sp = SP0;
    // R1: boot with requests present and a busy unit
    nmi_req = 1; mc_busy = 1; lvl_req = 7'h7F; cur_psw = 16'h0700;
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    #2;
    chk(pc_load && pc_load_val == BOOT, "R1 boot vector", pc_load_val, BOOT);
    chk(psw_load && psw_load_val == 16'h0, "R1 boot psw", 32'(psw_load_val), 32'h0);
    chk(!mem_wr_en && !mc_abort, "R1 no save or abort", 32'({mem_wr_en, mc_abort}), 32'h0);
    chk(sp_val == SP0, "R1 sp init", sp_val, SP0);
    nmi_req = 0; mc_busy = 0; lvl_req = '0;
    @(negedge clk); #2;
    chk(!mem_wr_en && !stall, "R1 nothing taken at boot", 32'(mem_wr_en), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R8 and R5: return restores the last frame and clears the flag
    @(negedge clk);
    cur_psw = 16'h0700; rti_req = 1;
    #2 chk(stall, "R8 return starts", 32'(stall), 32'h1);
    @(negedge clk); rti_req = 0; #2;
    chk(mem_rd_en && mem_rd_addr == exp_sp + 4 && !mem_wr_en, "R8 read pc slot",
        mem_rd_addr, exp_sp + 4);
    @(negedge clk); #2;
    chk(mem_rd_en && mem_rd_addr == exp_sp, "R8 read psw slot", mem_rd_addr, exp_sp);
    @(negedge clk); #2;
    chk(pc_load && pc_load_val == last_pc, "R8 pc restored", pc_load_val, last_pc);
    chk(psw_load && psw_load_val == last_psw, "R8 psw restored",
        32'(psw_load_val), 32'(last_psw));
    @(negedge clk); #2;
    exp_sp = exp_sp + 8;
    chk(sp_val == exp_sp, "R8 sp rise", sp_val, exp_sp);
    chk(!restart_flag, "R5 flag cleared by return", 32'(restart_flag), 32'h0);

    // R9: a pulse during a save sequence is dropped
    cur_psw = 16'h0700; cur_pc = 32'h3000; lvl_req = 7'b0000001;
    @(negedge clk); lvl_req = '0; nmi_req = 1;
    #2 chk(mem_wr_en, "R9 save running", 32'(mem_wr_en), 32'h1);
    @(negedge clk); nmi_req = 0; #2;
    chk(pc_load_val == want_vec(1'b0, 3'd0), "R9 entry kept its level",
        pc_load_val, want_vec(1'b0, 3'd0));
    @(negedge clk); #2;
    exp_sp = exp_sp - 8;
    chk(!mem_wr_en && !stall, "R9 pulse left no trace", 32'({mem_wr_en, stall}), 32'h0);

    // R10: return and interrupt in the same cycle
    cur_pc = 32'h2000; rti_req = 1; nmi_req = 1;
    @(negedge clk); rti_req = 0; nmi_req = 0; #2;
    chk(mem_wr_en && !mem_rd_en && mem_wr_data == 32'h2000, "R10 interrupt wins",
        mem_wr_data, 32'h2000);
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule